// File: doc/BRIEF.md
# Configuration Word Loader for a Frequency Synthesizer

This block builds the 40-bit configuration word for a direct digital synthesizer core. An external host writes the word one load at a time. Each load is marked by a rising edge on an asynchronous word-load clock. The host can use either of two formats. In the first, it writes five bytes on an 8-bit bus. In the second, it writes forty single bits on one lane of that same bus. The loads fill a staging register, and the core does not see them yet.

A separate asynchronous update strobe copies the staging register into the active register. The core is driven from the active register. The copy also rewinds the position counters, so the next load starts a new word.

The top byte of the active word is the control byte. It holds a 5-bit phase offset, a power-down flag, the load-format flag and the reference-multiplier enable. The lower 32 bits are the frequency tuning word. The load format in force at any time is the one held in the active control byte. Both asynchronous inputs pass through a two-flop synchronizer, and the block acts only on their rising edges.

Top module: `cfg_word_loader`

## Requirements
- R1: While reset is asserted, and until the first update afterwards, every output is zero. The staging register and both position counters are also cleared, and the load format is parallel.
- R2: In parallel format the first load writes the control byte. Loads two to five write the tuning word, most significant byte first. Each load only changes the staging register.
- R3: The active control byte is decoded as follows: bits 7:3 give the phase offset, bit 2 gives power-down, bit 1 gives serial format and bit 0 gives the multiplier enable.
- R4: In serial format each load takes one bit from data bus bit 7. Bits arrive least significant first: tuning word bits 0 to 31, then control bits 0 to 7.
- R5: The outputs change only when an update strobe copies the whole staging register into the active register.
- R6: An update strobe sets the byte counter and the bit counter to zero. The next parallel load therefore writes the control byte again, even after a partial sequence.
- R7: Parallel loads after the fifth leave the staging register unchanged until the next update.
- R8: Serial loads after the fortieth leave the staging register unchanged until the next update.
- R9: The load format is taken from the active control byte. An update with bit 1 set makes later loads serial. An update with bit 1 clear makes them parallel.
- R10: A rising edge on either asynchronous input takes effect at the third system clock edge after it. A level that stays high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wload_in | input | 1 | Asynchronous word-load clock |
| fupd_in | input | 1 | Asynchronous frequency-update strobe |
| data_in | input | 8 | Parallel byte, or the serial bit on bit 7 |
| tune_word | output | 32 | Active frequency tuning word |
| phase_off | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| serial_fmt | output | 1 | Active load format, 1 means serial |
| mult_en | output | 1 | Active reference-multiplier enable |

## Verification
The parallel path is driven with full five-byte sequences that carry distinct byte values. A swapped byte order or a misplaced control field therefore shows up in the outputs. A partial two-byte sequence followed by an update shows whether the counter rewinds. A sixth byte that differs from every earlier one shows whether the staging register is guarded at the end of a word. The serial path gets an asymmetric 40-bit pattern, which tells LSB-first order apart from MSB-first and the tuning bits apart from the control bits. Serial extra bits, the return to parallel format and a long-held load level each test one more rule. The outputs are compared with a behavioural model on every clock, and that cycle-exact comparison pins the three-edge latency.

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
  parameter int TUNE_W   = 32,
  parameter int CTRL_W   = 8,
  parameter int PHASE_W  = 5,
  parameter int SER_LANE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wload_in,
  input  logic               fupd_in,
  input  logic [7:0]         data_in,
  output logic [TUNE_W-1:0]  tune_word,
  output logic [PHASE_W-1:0] phase_off,
  output logic               pwr_down,
  output logic               serial_fmt,
  output logic               mult_en
);
  localparam int WORD_W = TUNE_W + CTRL_W;
  localparam int NBYTES = WORD_W / 8;
  localparam int BC_W   = $clog2(NBYTES + 1);
  localparam int SC_W   = $clog2(WORD_W + 1);

  logic [2:0] wl_s, up_s;
  logic [WORD_W-1:0] stage, active;
  logic [BC_W-1:0] byte_cnt;
  logic [SC_W-1:0] bit_cnt;
  logic wl_rise, up_rise;
  logic [CTRL_W-1:0] ctrl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wl_s <= '0;
      up_s <= '0;
    end else begin
      wl_s <= {wl_s[1:0], wload_in};
      up_s <= {up_s[1:0], fupd_in};
    end

  assign wl_rise = wl_s[1] & ~wl_s[2];
  assign up_rise = up_s[1] & ~up_s[2];

  assign ctrl       = active[WORD_W-1:TUNE_W];
  assign tune_word  = active[TUNE_W-1:0];
  assign phase_off  = ctrl[CTRL_W-1 -: PHASE_W];
  assign pwr_down   = ctrl[2];
  assign serial_fmt = ctrl[1];
  assign mult_en    = ctrl[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stage    <= '0;
      active   <= '0;
      byte_cnt <= '0;
      bit_cnt  <= '0;
    end else if (up_rise) begin
      active   <= stage;
      byte_cnt <= '0;
      bit_cnt  <= '0;
    end else if (wl_rise) begin
      if (serial_fmt) begin
        if (bit_cnt < SC_W'(WORD_W)) begin
          stage   <= {data_in[SER_LANE], stage[WORD_W-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (byte_cnt < BC_W'(NBYTES)) begin
        stage[WORD_W-1 - 8*int'(byte_cnt) -: 8] <= data_in;
        byte_cnt <= byte_cnt + 1'b1;
      end
    end

  // R5
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_rise |=> $stable(active));
  // R6
  counters_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rise |=> (byte_cnt == '0 && bit_cnt == '0));
  // R7
  byte_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_rise && !up_rise && !serial_fmt && byte_cnt == BC_W'(NBYTES)) |=> $stable(stage));
  // R8
  bit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_rise && !up_rise && serial_fmt && bit_cnt == SC_W'(WORD_W)) |=> $stable(stage));
  // R10
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wl_rise |=> !wl_rise);
endmodule

// File: tb/sim_cfg_word_loader.sv
module sim_cfg_word_loader;
  logic clk = 0, rst_n = 0, wload_in = 0, fupd_in = 0;
  logic [7:0] data_in = 0;
  logic [31:0] tune_word;
  logic [4:0] phase_off;
  logic pwr_down, serial_fmt, mult_en;

  cfg_word_loader u0 (.clk, .rst_n, .wload_in, .fupd_in, .data_in,
    .tune_word, .phase_off, .pwr_down, .serial_fmt, .mult_en);

  always #2 clk = ~clk;

  logic [39:0] m_stage = 0, m_active = 0;
  int m_bytes = 0, m_bits = 0;
  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit running = 0;

  task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(40'(tune_word), 40'(m_active[31:0]), "tune_word");
    chk(40'(phase_off), 40'(m_active[39:35]), "phase_off R3");
    chk(40'(pwr_down), 40'(m_active[34]), "pwr_down R3");
    chk(40'(serial_fmt), 40'(m_active[33]), "serial_fmt R3/R9");
    chk(40'(mult_en), 40'(m_active[32]), "mult_en R3");
  endtask

  always @(negedge clk) if (running) compare_all();

  task automatic model_load(input logic [7:0] d);
    if (m_active[33]) begin
      if (m_bits < 40) begin m_stage = {d[7], m_stage[39:1]}; m_bits++; end
    end else if (m_bytes < 5) begin
      m_stage[39 - 8*m_bytes -: 8] = d;
      m_bytes++;
    end
  endtask

  task automatic wl(input logic [7:0] d, input int hold = 2);
    @(negedge clk); data_in = d; wload_in = 1;
    repeat (3) @(posedge clk);
    model_load(d);
    repeat (hold) @(negedge clk);
    wload_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic upd();
    @(negedge clk); fupd_in = 1;
    repeat (3) @(posedge clk);
    m_active = m_stage; m_bytes = 0; m_bits = 0;
    repeat (2) @(negedge clk);
    fupd_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic par_word(input logic [7:0] c, input logic [31:0] t);
    wl(c); wl(t[31:24]); wl(t[23:16]); wl(t[15:8]); wl(t[7:0]);
  endtask

  task automatic ser_word(input logic [39:0] w);
    for (int i = 0; i < 40; i++) wl(w[i] ? 8'h80 : 8'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare_all();
    rst_n = 1;
    running = 1;
    repeat (4) @(negedge clk);
    // R2 R5: staged bytes stay hidden until the update, then land in place
    cur_req = "R2/R5";
    par_word(8'hA5, 32'h1234_5678);
    cur_req = "R3/R5"; upd();
    cur_req = "R3"; chk(40'(phase_off), 40'd20, "phase 0xA5"); chk(40'(pwr_down), 40'd1, "pwr");
    chk(40'(mult_en), 40'd1, "mult"); chk(40'(tune_word), 40'h12345678, "tune R2");
    // R6: partial sequence then update, the next byte is control again
    cur_req = "R6";
    wl(8'h11); wl(8'h22); upd();
    par_word(8'h58, 32'hCAFE_0042); upd();
    chk(40'(tune_word), 40'hCAFE0042, "tune after rewind");
    // R7: sixth byte ignored
    cur_req = "R7";
    par_word(8'hF9, 32'h0BAD_F00D); wl(8'h66); upd();
    chk(40'(tune_word), 40'h0BADF00D, "tune after extra byte");
    // R9: switch to serial
    cur_req = "R9";
    par_word(8'h02, 32'h0000_0001); upd();
    chk(40'(serial_fmt), 40'd1, "serial on");
    // R4 R8: serial word LSB first, then extra bits
    cur_req = "R4";
    ser_word({8'b1011_0101, 32'h8000_6C31});
    cur_req = "R8";
    wl(8'h80); wl(8'h00); wl(8'h80);
    cur_req = "R4/R8"; upd();
    chk(40'(tune_word), 40'h80006C31, "serial tune");
    chk(40'(phase_off), 40'd22, "serial phase"); chk(40'(serial_fmt), 40'd0, "serial cleared");
    // R9 back in parallel; R10 held level counts once
    cur_req = "R10";
    wl(8'hC1, 12); wl(8'hDE); wl(8'hAD); wl(8'hBE); wl(8'hEF);
    cur_req = "R9/R10"; upd();
    chk(40'(tune_word), 40'hDEADBEEF, "held load once");
    chk(40'(phase_off), 40'd24, "parallel again");
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule